// File: doc/BRIEF.md
# SDRAM Command Front End

This block is the device-side command stage of a four-bank single-data-rate SDRAM. On every rising clock edge it samples the clock-enable pin, the four active-low command pins, the data-mask pin, the bank select and the address bus. It turns them into one-cycle command strobes for the rest of the device. The memory array, refresh counting and burst address generation sit elsewhere and consume these strobes.

The block keeps an idle or active flag for each bank. It refuses commands that the current bank state does not permit, and reports each refusal with a one-cycle error pulse. It also follows the clock-enable pin through clock suspend, power-down and self-refresh. It enforces the quiet cycle that must follow a wake-up. It produces two data-mask timings: a zero-latency write mask and an output disable that lags the mask pin by two clocks.

Top module: `sdram_cmd_front`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are zero after that edge. That means every bank idle, `mode_state` 0 (normal), no strobe, no error and no masking.
- R2: The command code is {cs_n,ras_n,cas_n,we_n}. The codes are 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read and 0111 NOP. Any code with cs_n high is deselect, which behaves like NOP. A legal command sampled at an edge gives its strobe for exactly the one cycle after that edge.
- R3: The bank is selected by `ba` read as an unsigned number (0 to 3). An accepted activate sets that bank's `bank_active` bit. `cmd_bank`, `cmd_addr` and `cmd_ap` (address bit 10) show the values sampled at the last edge.
- R4: With address bit 10 high, an accepted precharge makes every bank idle. With bit 10 low, it makes only the selected bank idle. Precharge is legal in any bank state.
- R5: Read and write are accepted only when the selected bank is active. With address bit 10 high they request auto-precharge, and the bank is reported idle from the strobe cycle on.
- R6: Mode set and refresh are accepted only when every bank is idle. Activate is accepted only when the selected bank is idle.
- R7: A refused command does not change any bank or mode state and gives no strobe. It raises `cmd_err` for one cycle. Code 0110 is always refused.
- R8: If `cke` is low at an edge in normal mode, the command at that edge is not executed, except as in R9. `mode_state` becomes 1 (clock suspend) if any bank is active, otherwise 2 (power-down). While `mode_state` is not 0, no command is executed.
- R9: Refresh with `cke` low in normal mode enters self-refresh (`mode_state` 3) and pulses `str_sref` when every bank is idle. With any bank active it raises `cmd_err` and enters clock suspend instead.
- R10: If `cke` is high at an edge while `mode_state` is not 0, the mode returns to 0 after that edge and the command at that edge is ignored. At the following edge any command other than NOP or deselect is refused with `cmd_err`.
- R11: `dq_wr_mask` after an edge equals `dqm` sampled at that edge (zero latency).
- R12: `dq_out_dis` after edge k+2 equals `dqm` sampled at edge k. The mask pipelines advance only at edges where `mode_state` is 0 and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus |
| bank_active | output | 4 | Per-bank active flag |
| mode_state | output | 2 | 0 normal, 1 suspend, 2 power-down, 3 self-refresh |
| str_mrs | output | 1 | Mode set accepted |
| str_ref | output | 1 | Auto refresh accepted |
| str_act | output | 1 | Activate accepted |
| str_rd | output | 1 | Read accepted |
| str_wr | output | 1 | Write accepted |
| str_pre | output | 1 | Precharge accepted |
| str_sref | output | 1 | Self-refresh entered |
| cmd_err | output | 1 | Refused command pulse |
| cmd_bank | output | 2 | Bank sampled at last edge |
| cmd_addr | output | 12 | Address sampled at last edge |
| cmd_ap | output | 1 | Address bit 10 sampled at last edge |
| dq_out_dis | output | 1 | Read output disable (high impedance) |
| dq_wr_mask | output | 1 | Write data mask |

## Verification
The bench builds the block with its defaults: four banks, a 12-bit address, a read mask latency of 2 and a write mask latency of 0. Four banks make every value of the two-bit bank select meaningful, so single-bank and all-bank precharge can be told apart. The two-stage read delay lets a clock-enable drop freeze a mask value part-way down the pipeline, and the bench checks that the value survives the frozen cycles. Random clock-enable drops with random bank states reach both the suspend and the power-down branch, and the quiet cycle after wake-up.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_SUSP = 2'd1,
    MODE_PDN  = 2'd2,
    MODE_SREF = 2'd3
  } dev_mode_e;

  typedef enum logic [3:0] {
    K_DES  = 4'd0,
    K_NOP  = 4'd1,
    K_MRS  = 4'd2,
    K_REF  = 4'd3,
    K_PRE  = 4'd4,
    K_ACT  = 4'd5,
    K_WR   = 4'd6,
    K_RD   = 4'd7,
    K_RSVD = 4'd8
  } cmd_kind_e;

endpackage

// File: rtl/sdcf_cmd_decode.sv
module sdcf_cmd_decode
  import sdcf_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_e kind
);

  always_comb begin
    if (cs_n) begin
      kind = K_DES;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  kind = K_MRS;
        3'b001:  kind = K_REF;
        3'b010:  kind = K_PRE;
        3'b011:  kind = K_ACT;
        3'b100:  kind = K_WR;
        3'b101:  kind = K_RD;
        3'b110:  kind = K_RSVD;
        default: kind = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdcf_cke_ctl.sv
module sdcf_cke_ctl
  import sdcf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cke,
  input  cmd_kind_e kind,
  input  logic      any_active,
  output dev_mode_e mode,
  output logic      run,
  output logic      exec_en,
  output logic      guard_err,
  output logic      sref_go,
  output logic      sref_err
);

  logic guard_q;
  logic quiet;
  logic sref_req;

  assign run      = (mode == MODE_RUN);
  assign quiet    = (kind == K_NOP) || (kind == K_DES);
  assign guard_err = run && guard_q && !quiet;
  assign sref_req = run && !cke && (kind == K_REF) && !guard_err;
  assign sref_go  = sref_req && !any_active;
  assign sref_err = sref_req && any_active;
  assign exec_en  = run && cke && !guard_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_RUN;
      guard_q <= 1'b0;
    end else if (run) begin
      guard_q <= 1'b0;
      if (!cke) begin
        if (sref_go)         mode <= MODE_SREF;
        else if (any_active) mode <= MODE_SUSP;
        else                 mode <= MODE_PDN;
      end
    end else if (cke) begin
      mode    <= MODE_RUN;
      guard_q <= 1'b1;
    end
  end

  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    (!run && cke) |=> (mode == MODE_RUN)); // R10

endmodule

// File: rtl/sdcf_bank_track.sv
module sdcf_bank_track
  import sdcf_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 apply,
  input  cmd_kind_e            kind,
  input  logic [BA_W-1:0]      ba,
  input  logic                 ap,
  output logic [NUM_BANKS-1:0] active
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        active[b] <= 1'b0;
      end else if (apply) begin
        case (kind)
          K_ACT:      if (hit) active[b] <= 1'b1;
          K_PRE:      if (hit || ap) active[b] <= 1'b0;
          K_RD, K_WR: if (hit && ap) active[b] <= 1'b0;
          default:    ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdcf_dqm_delay.sv
module sdcf_dqm_delay #(
  parameter int LAT = 2,
  localparam int DEPTH = LAT + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] sh;

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst)      sh <= '0;
      else if (adv) sh <= din;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst)      sh <= '0;
      else if (adv) sh <= {sh[DEPTH-2:0], din};
    end
  end

  assign dout = sh[DEPTH-1];

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!adv && !$past(rst)) |=> $stable(dout)); // R12

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcf_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 12,
  parameter int AP_BIT      = 10,
  parameter int RD_MASK_LAT = 2,
  parameter int WR_MASK_LAT = 0,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 dqm,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_active,
  output logic [1:0]           mode_state,
  output logic                 str_mrs,
  output logic                 str_ref,
  output logic                 str_act,
  output logic                 str_rd,
  output logic                 str_wr,
  output logic                 str_pre,
  output logic                 str_sref,
  output logic                 cmd_err,
  output logic [BA_W-1:0]      cmd_bank,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic                 cmd_ap,
  output logic                 dq_out_dis,
  output logic                 dq_wr_mask
);

  cmd_kind_e kind;
  dev_mode_e mode;
  logic      run, exec_en, guard_err, sref_go, sref_err;
  logic      any_active, sel_active, legal, apply, ap_in;

  sdcf_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .kind  (kind)
  );

  assign any_active = |bank_active;
  assign sel_active = bank_active[ba];
  assign ap_in      = addr[AP_BIT];

  sdcf_cke_ctl u_cke (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .kind       (kind),
    .any_active (any_active),
    .mode       (mode),
    .run        (run),
    .exec_en    (exec_en),
    .guard_err  (guard_err),
    .sref_go    (sref_go),
    .sref_err   (sref_err)
  );

  always_comb begin
    case (kind)
      K_MRS, K_REF: legal = !any_active;
      K_ACT:        legal = !sel_active;
      K_RD, K_WR:   legal = sel_active;
      K_RSVD:       legal = 1'b0;
      default:      legal = 1'b1;
    endcase
  end

  assign apply = exec_en && legal;

  sdcf_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk    (clk),
    .rst    (rst),
    .apply  (apply),
    .kind   (kind),
    .ba     (ba),
    .ap     (ap_in),
    .active (bank_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      str_mrs  <= 1'b0;
      str_ref  <= 1'b0;
      str_act  <= 1'b0;
      str_rd   <= 1'b0;
      str_wr   <= 1'b0;
      str_pre  <= 1'b0;
      str_sref <= 1'b0;
      cmd_err  <= 1'b0;
      cmd_bank <= '0;
      cmd_addr <= '0;
      cmd_ap   <= 1'b0;
    end else begin
      str_mrs  <= apply && (kind == K_MRS);
      str_ref  <= apply && (kind == K_REF);
      str_act  <= apply && (kind == K_ACT);
      str_rd   <= apply && (kind == K_RD);
      str_wr   <= apply && (kind == K_WR);
      str_pre  <= apply && (kind == K_PRE);
      str_sref <= sref_go;
      cmd_err  <= (exec_en && !legal) || guard_err || sref_err;
      cmd_bank <= ba;
      cmd_addr <= addr;
      cmd_ap   <= ap_in;
    end
  end

  assign mode_state = mode;

  sdcf_dqm_delay #(.LAT(WR_MASK_LAT)) u_wmask (
    .clk  (clk),
    .rst  (rst),
    .adv  (run),
    .din  (dqm),
    .dout (dq_wr_mask)
  );

  sdcf_dqm_delay #(.LAT(RD_MASK_LAT)) u_rdis (
    .clk  (clk),
    .rst  (rst),
    .adv  (run),
    .din  (dqm),
    .dout (dq_out_dis)
  );

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str_mrs, str_ref, str_act, str_rd, str_wr, str_pre, str_sref, cmd_err})); // R2
  AST_ACT_MARKS_BANK: assert property (@(posedge clk) disable iff (rst)
    str_act |-> bank_active[cmd_bank]); // R3
  AST_PREALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (str_pre && cmd_ap) |-> (bank_active == '0)); // R4
  AST_AUTOPRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((str_rd || str_wr) && cmd_ap) |-> !bank_active[cmd_bank]); // R5
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_RUN) |-> !(str_mrs || str_ref || str_act || str_rd || str_wr || str_pre)); // R8
  AST_LOWPWR_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_PDN) || (mode == MODE_SREF)) |-> (bank_active == '0)); // R9

endmodule

// File: tb/sdram_cmd_front_test.sv
module sdram_cmd_front_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  bank_active;
  logic [1:0]  mode_state, cmd_bank;
  logic [11:0] cmd_addr;
  logic str_mrs, str_ref, str_act, str_rd, str_wr, str_pre, str_sref, cmd_err, cmd_ap;
  logic dq_out_dis, dq_wr_mask;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_cmd_front uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dqm(dqm), .ba(ba), .addr(addr), .bank_active(bank_active),
    .mode_state(mode_state), .str_mrs(str_mrs), .str_ref(str_ref), .str_act(str_act),
    .str_rd(str_rd), .str_wr(str_wr), .str_pre(str_pre), .str_sref(str_sref),
    .cmd_err(cmd_err), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
    .dq_out_dis(dq_out_dis), .dq_wr_mask(dq_wr_mask)
  );

  // reference model state
  logic [3:0] m_act;
  logic [1:0] m_mode;
  logic       m_guard;
  logic [2:0] m_rd;       // read-disable chain, [2] is the output
  logic       m_wm;
  logic [7:0] m_ev;       // {mrs,ref,act,rd,wr,pre,sref,err}
  logic [1:0] m_bank;
  logic [11:0] m_addr;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_act = '0; m_mode = 2'd0; m_guard = 1'b0; m_rd = '0; m_wm = 1'b0;
    m_ev = '0; m_bank = '0; m_addr = '0;
  endtask

  // computes next state for one edge from the pin values now applied
  task automatic model_edge();
    logic [3:0] code;
    logic quiet, gv, busy, ap, ok;
    code  = {cs_n, ras_n, cas_n, we_n};
    quiet = cs_n || (code == 4'b0111);
    busy  = |m_act;
    ap    = addr[10];
    m_ev  = '0;
    m_bank = ba;
    m_addr = addr;
    if (m_mode == 2'd0) begin
      m_rd = {m_rd[1:0], dqm};
      m_wm = dqm;
      gv = m_guard && !quiet;
      m_guard = 1'b0;
      if (gv) m_ev[0] = 1'b1;
      if (!cke) begin
        if (!gv && !cs_n && code == 4'b0001) begin
          if (!busy) begin m_mode = 2'd3; m_ev[1] = 1'b1; end
          else begin m_mode = 2'd1; m_ev[0] = 1'b1; end
        end else begin
          m_mode = busy ? 2'd1 : 2'd2;
        end
      end else if (!gv && !cs_n) begin
        case (code)
          4'b0000: begin ok = !busy; if (ok) m_ev[7] = 1'b1; end
          4'b0001: begin ok = !busy; if (ok) m_ev[6] = 1'b1; end
          4'b0011: begin ok = !m_act[ba]; if (ok) begin m_ev[5] = 1'b1; m_act[ba] = 1'b1; end end
          4'b0101: begin ok = m_act[ba]; if (ok) begin m_ev[4] = 1'b1; if (ap) m_act[ba] = 1'b0; end end
          4'b0100: begin ok = m_act[ba]; if (ok) begin m_ev[3] = 1'b1; if (ap) m_act[ba] = 1'b0; end end
          4'b0010: begin ok = 1'b1; m_ev[2] = 1'b1; if (ap) m_act = '0; else m_act[ba] = 1'b0; end
          4'b0110: ok = 1'b0;
          default: ok = 1'b1;
        endcase
        if (!ok) m_ev[0] = 1'b1;
      end
    end else if (cke) begin
      m_mode = 2'd0;
      m_guard = 1'b1;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "bank_active", 32'(bank_active), 32'(m_act));
    chk(tag, "mode_state", 32'(mode_state), 32'(m_mode));
    chk(tag, "strobes", 32'({str_mrs, str_ref, str_act, str_rd, str_wr, str_pre}), 32'(m_ev[7:2]));
    chk(tag, "str_sref", 32'(str_sref), 32'(m_ev[1]));
    chk(tag, "cmd_err", 32'(cmd_err), 32'(m_ev[0]));
    chk(tag, "cmd_fields", 32'({cmd_bank, cmd_ap, cmd_addr}), 32'({m_bank, m_addr[10], m_addr}));
    chk(tag, "dq_wr_mask", 32'(dq_wr_mask), 32'(m_wm));
    chk(tag, "dq_out_dis", 32'(dq_out_dis), 32'(m_rd[2]));
  endtask

  task automatic step(input string tag, input logic k, input logic [3:0] code,
                      input logic dm, input logic [1:0] b, input logic a10);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = code; dqm = dm; ba = b;
    addr = 12'($urandom);
    addr[10] = a10;
    model_edge();
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_RSV = 4'b0110, C_NOP = 4'b0111, C_DES = 4'b1111;

  initial begin
    #800000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    compare("R1");
    @(negedge clk);
    rst = 1'b0;

    // bank activation, auto-precharge, precharge variants
    step("R3", 1, C_ACT, 0, 2'd2, 0);
    step("R3", 1, C_ACT, 0, 2'd1, 0);
    step("R6", 1, C_ACT, 0, 2'd1, 0);      // already active: refused
    step("R5", 1, C_RD,  0, 2'd2, 1);      // read with auto-precharge
    step("R5", 1, C_WR,  0, 2'd2, 0);      // bank now idle: refused
    step("R5", 1, C_WR,  0, 2'd1, 0);
    step("R4", 1, C_PRE, 0, 2'd1, 0);
    step("R3", 1, C_ACT, 0, 2'd0, 0);
    step("R3", 1, C_ACT, 0, 2'd3, 0);
    step("R6", 1, C_REF, 0, 2'd0, 0);      // bank active: refused
    step("R6", 1, C_MRS, 0, 2'd0, 0);      // refused
    step("R4", 1, C_PRE, 0, 2'd1, 1);      // all banks
    step("R6", 1, C_MRS, 0, 2'd0, 0);
    step("R6", 1, C_REF, 0, 2'd0, 0);
    step("R7", 1, C_RSV, 0, 2'd0, 0);
    step("R7", 1, C_RD,  0, 2'd3, 0);
    step("R2", 1, C_DES, 0, 2'd0, 0);
    step("R2", 1, C_NOP, 0, 2'd0, 0);

    // clock suspend with an active bank
    step("R3", 1, C_ACT, 0, 2'd0, 0);
    step("R8", 0, C_NOP, 1, 2'd0, 0);
    step("R8", 0, C_ACT, 0, 2'd1, 0);
    step("R12", 0, C_NOP, 0, 2'd0, 0);
    step("R10", 1, C_WR, 0, 2'd0, 0);      // wake edge, ignored
    step("R10", 1, C_WR, 0, 2'd0, 0);      // quiet edge violated
    step("R12", 1, C_NOP, 0, 2'd0, 0);
    step("R12", 1, C_NOP, 0, 2'd0, 0);

    // power-down with all idle
    step("R4", 1, C_PRE, 0, 2'd0, 1);
    step("R8", 0, C_NOP, 0, 2'd0, 0);
    step("R8", 0, C_NOP, 0, 2'd0, 0);
    step("R10", 1, C_NOP, 0, 2'd0, 0);
    step("R10", 1, C_DES, 0, 2'd0, 0);
    step("R10", 1, C_ACT, 0, 2'd2, 0);

    // self-refresh refused with an active bank, then accepted
    step("R9", 0, C_REF, 0, 2'd0, 0);
    step("R9", 1, C_NOP, 0, 2'd0, 0);
    step("R9", 1, C_NOP, 0, 2'd0, 0);
    step("R4", 1, C_PRE, 0, 2'd0, 1);
    step("R9", 0, C_REF, 0, 2'd0, 0);
    step("R9", 0, C_NOP, 0, 2'd0, 0);
    step("R10", 1, C_NOP, 0, 2'd0, 0);
    step("R10", 1, C_NOP, 0, 2'd0, 0);

    // mask timing
    step("R11", 1, C_NOP, 1, 2'd0, 0);
    step("R11", 1, C_NOP, 0, 2'd0, 0);
    step("R12", 1, C_NOP, 0, 2'd0, 0);
    step("R12", 1, C_NOP, 1, 2'd0, 0);
    step("R12", 1, C_NOP, 1, 2'd0, 0);
    step("R12", 1, C_NOP, 0, 2'd0, 0);
    step("R12", 1, C_NOP, 0, 2'd0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic k;
      logic [3:0] c;
      k = ($urandom_range(0, 99) < 88);
      c = ($urandom_range(0, 99) < 15) ? 4'b1000 | 4'($urandom) : {1'b0, 3'($urandom)};
      step("R2", k, c, 1'($urandom), 2'($urandom), ($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule